// File: doc/BRIEF.md
# Setup-Buffer Destination Address Filter

This block sits on the receive side of an Ethernet port. It decides whether an incoming frame should reach the host, based on the frame's 48-bit destination address. Three rules apply. In promiscuous mode every frame is accepted. A group (multicast or broadcast) destination is always accepted. A unicast destination is accepted only when it matches an address held in a small table.

Software fills the table by handing the block a fixed-layout setup buffer of 192 bytes. The bytes are streamed in after a start strobe. The buffer holds 16 slots of 12 bytes each, and only six byte lanes of each slot carry address bytes. As each slot completes, the parser extracts its address. Group addresses are discarded and unicast addresses are packed into the table from index 0. The number of stored entries is visible on an output.

While a load is in progress the block reports busy. An address check issued during that time is parked and answered once the new table is complete.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `busy`, `acc_valid` and `entry_count` are all 0.
- R2: A pulse on `load_start` begins a load. `busy` is 1 from the next clock edge. The load then consumes exactly 192 bytes, taken on cycles where `load_valid` is 1, as 16 slots of 12 bytes. `busy` falls on the edge that consumes the 192nd byte.
- R3: Within a slot, the address bytes 0 to 5 are taken from slot byte offsets 0, 1, 4, 5, 8 and 9, in that order. Address byte 0 corresponds to `chk_addr[47:40]` and byte 5 to `chk_addr[7:0]`. The other six offsets have no effect on the table.
- R4: A slot whose address byte 0 has bit 0 set (a group address) is not stored. Unicast slots are stored in slot order, packed from index 0. `entry_count` equals the number stored.
- R5: `load_start` sets `entry_count` to 0 on the next edge. Addresses from any earlier load no longer match, even if their storage has not been overwritten.
- R6: When `promisc_en` is 1 with a check request, that frame is accepted.
- R7: A destination with `chk_addr[40]` set is accepted.
- R8: Otherwise, a destination is accepted only if it equals one of the stored entries whose index is below `entry_count`.
- R9: A check request made while no load is running or starting produces `acc_valid` = 1 with the decision on `acc_flag` at the next clock edge.
- R10: A check request made while `busy` is 1, or in the same cycle as `load_start`, is held. It is decided against the new table. Its result appears on the edge after the one where `busy` falls. If a later request arrives while one is held, the later one replaces it.
- R11: Bytes presented with `load_valid` while no load is running are ignored: `entry_count` and the accept decisions are unchanged.
- R12: A `load_start` during a load restarts parsing at slot 0, byte offset 0, with an empty table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | Begins a setup-buffer load |
| load_valid | input | 1 | `load_byte` carries a buffer byte this cycle |
| load_byte | input | 8 | Setup-buffer byte, in buffer order |
| promisc_en | input | 1 | Promiscuous mode (accept all), sampled with the request |
| chk_valid | input | 1 | Check request strobe |
| chk_addr | input | 48 | Destination address to check, byte 0 in [47:40] |
| busy | output | 1 | Table load in progress |
| acc_valid | output | 1 | `acc_flag` holds a fresh decision |
| acc_flag | output | 1 | 1 = deliver frame, 0 = drop |
| entry_count | output | 5 | Number of unicast entries stored |

## Verification
A check on an idle block is answered on the first edge after the request. The bench raises `chk_valid` at a falling edge and samples `acc_valid`/`acc_flag` at the following falling edge. Load bytes are driven one per cycle. `busy` and `entry_count` are therefore sampled at the falling edge just after the edge that consumed the 192nd byte, when `busy` must already be 0.

For a request parked during a load, the bench first confirms that `acc_valid` is still 0 at that same falling edge. It then expects the result one cycle later and checks it against the new table. A table filled from an older seed would reject the same address.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int unsigned MAC_BYTES = 6;
  localparam int unsigned MAC_W     = 8 * MAC_BYTES;
  // Bit 0 of address byte 0 marks a group address; byte 0 is the top byte.
  localparam int unsigned GROUP_BIT = MAC_W - 8;

  typedef logic [MAC_W-1:0] mac_t;

  function automatic logic is_group(input mac_t a);
    return a[GROUP_BIT];
  endfunction

endpackage

// File: rtl/daf_setup_parser.sv
module daf_setup_parser
  import daf_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned ENTRY_BYTES = 12,
  parameter logic [ENTRY_BYTES-1:0] USED_MASK = 12'h333
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_start,
  input  logic       load_valid,
  input  logic [7:0] load_byte,
  output logic       busy,
  output logic       tbl_clear,
  output logic       tbl_wr,
  output mac_t       tbl_wr_data
);

  function automatic int unsigned last_used_off(input logic [ENTRY_BYTES-1:0] m);
    int unsigned r;
    r = 0;
    for (int unsigned k = 0; k < ENTRY_BYTES; k++) begin
      if (m[k]) r = k;
    end
    return r;
  endfunction

  localparam int unsigned OFF_W    = (ENTRY_BYTES > 1) ? $clog2(ENTRY_BYTES) : 1;
  localparam int unsigned ENT_W    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int unsigned LAST_OFF = last_used_off(USED_MASK);
  localparam int unsigned ASM_W    = MAC_W - 8;

  logic             busy_q, busy_d, busy_en;
  logic [OFF_W-1:0] off_q, off_d;
  logic [ENT_W-1:0] ent_q, ent_d;
  logic             pos_en;
  logic [ASM_W-1:0] asm_q, asm_d;
  logic             asm_en;

  logic take, lane_used, at_last_lane, at_entry_end, at_last_entry;
  mac_t full_addr;

  // next-state logic
  always_comb begin
    take          = busy_q && load_valid && !load_start;
    lane_used     = USED_MASK[off_q];
    at_last_lane  = (off_q == OFF_W'(LAST_OFF));
    at_entry_end  = (off_q == OFF_W'(ENTRY_BYTES - 1));
    at_last_entry = (ent_q == ENT_W'(NUM_ENTRIES - 1));
    full_addr     = {asm_q, load_byte};

    busy_en = load_start || (take && at_entry_end && at_last_entry);
    busy_d  = load_start;

    pos_en = load_start || take;
    if (load_start) begin
      off_d = '0;
      ent_d = '0;
    end else begin
      off_d = at_entry_end ? '0 : off_q + OFF_W'(1);
      ent_d = at_entry_end ? (at_last_entry ? '0 : ent_q + ENT_W'(1)) : ent_q;
    end

    asm_en = take && lane_used;
    asm_d  = {asm_q[ASM_W-9:0], load_byte};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      off_q  <= '0;
      ent_q  <= '0;
    end else begin
      if (busy_en) busy_q <= busy_d;
      if (pos_en) begin
        off_q <= off_d;
        ent_q <= ent_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (asm_en) asm_q <= asm_d;
  end

  assign busy        = busy_q;
  assign tbl_clear   = load_start;
  assign tbl_wr      = take && lane_used && at_last_lane && !is_group(full_addr);
  assign tbl_wr_data = full_addr;

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> busy_q);

  assert_busy_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(load_valid && at_entry_end && at_last_entry));

  assert_restart_pos_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> (off_q == '0 && ent_q == '0));

  assert_idle_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !load_start) |=> $stable(off_q) && $stable(ent_q));

endmodule

// File: rtl/daf_addr_table.sv
module daf_addr_table
  import daf_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  mac_t             wr_data,
  input  mac_t             lookup,
  output logic             hit,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   cnt_en;
  logic                   room;
  logic [NUM_ENTRIES-1:0] hit_vec;

  always_comb begin
    room   = (cnt_q < CNT_W'(NUM_ENTRIES));
    cnt_en = clear || (wr_en && room);
    cnt_d  = clear ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    mac_t ent_q;
    logic we;
    assign we = wr_en && !clear && room && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk) begin
      if (we) ent_q <= wr_data;
    end
    assign hit_vec[i] = (CNT_W'(i) < cnt_q) && (ent_q == lookup);
  end

  assign hit   = |hit_vec;
  assign count = cnt_q;

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NUM_ENTRIES));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_clear_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned ENTRY_BYTES = 12,
  parameter logic [ENTRY_BYTES-1:0] USED_MASK = 12'h333,
  localparam int unsigned CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic             load_valid,
  input  logic [7:0]       load_byte,
  input  logic             promisc_en,
  input  logic             chk_valid,
  input  logic [47:0]      chk_addr,
  output logic             busy,
  output logic             acc_valid,
  output logic             acc_flag,
  output logic [CNT_W-1:0] entry_count
);

  logic tbl_clear, tbl_wr, tbl_hit;
  mac_t tbl_wr_data;

  daf_setup_parser #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ENTRY_BYTES (ENTRY_BYTES),
    .USED_MASK   (USED_MASK)
  ) parser_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_start  (load_start),
    .load_valid  (load_valid),
    .load_byte   (load_byte),
    .busy        (busy),
    .tbl_clear   (tbl_clear),
    .tbl_wr      (tbl_wr),
    .tbl_wr_data (tbl_wr_data)
  );

  // request hold slot
  logic pend_q, pend_d, pend_en;
  mac_t pend_addr_q;
  logic pend_prom_q;
  logic hold, fire, capture;
  mac_t eval_addr;
  logic eval_prom, accept;
  logic acc_valid_q, acc_flag_q;

  daf_addr_table #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .CNT_W       (CNT_W)
  ) table_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tbl_clear),
    .wr_en   (tbl_wr),
    .wr_data (tbl_wr_data),
    .lookup  (eval_addr),
    .hit     (tbl_hit),
    .count   (entry_count)
  );

  always_comb begin
    hold      = busy || load_start;
    fire      = !hold && (pend_q || chk_valid);
    capture   = chk_valid && (hold || pend_q);
    eval_addr = pend_q ? pend_addr_q : chk_addr;
    eval_prom = pend_q ? pend_prom_q : promisc_en;
    accept    = eval_prom || is_group(eval_addr) || tbl_hit;
    pend_en   = capture || fire;
    pend_d    = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      acc_valid_q <= 1'b0;
      acc_flag_q  <= 1'b0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      acc_valid_q <= fire;
      if (fire) acc_flag_q <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      pend_addr_q <= chk_addr;
      pend_prom_q <= promisc_en;
    end
  end

  assign acc_valid = acc_valid_q;
  assign acc_flag  = acc_flag_q;

  assert_promisc_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && eval_prom) |=> acc_flag_q);

  assert_group_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && eval_addr[GROUP_BIT]) |=> acc_flag_q);

  assert_idle_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !busy && !load_start && !pend_q) |=> acc_valid_q);

  assert_no_result_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_q |-> !$past(hold));

  assert_held_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !hold) |=> acc_valid_q);

endmodule

// File: tb/dest_addr_filter_tb_top.sv
module dest_addr_filter_tb_top;
  localparam int N  = 16;
  localparam int EB = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_start, load_valid, promisc_en, chk_valid;
  logic [7:0]  load_byte;
  logic [47:0] chk_addr;
  logic        busy, acc_valid, acc_flag;
  logic [4:0]  entry_count;

  always #10 clk = ~clk;

  dest_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_valid(load_valid),
    .load_byte(load_byte), .promisc_en(promisc_en), .chk_valid(chk_valid),
    .chk_addr(chk_addr), .busy(busy), .acc_valid(acc_valid), .acc_flag(acc_flag),
    .entry_count(entry_count)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [47:0] exp_tab [N];
  int exp_cnt = 0;

  function automatic logic [47:0] mk_addr(int seed, int i, bit grp);
    logic [7:0] b0, b1, b2, b3, b4, b5;
    b0 = (8'(i * 4 + seed * 2) & 8'hFE) | {7'b0, grp};
    b1 = 8'(8'h10 + i);
    b2 = 8'(seed);
    b3 = 8'h3C ^ 8'(i);
    b4 = 8'(8'hC0 + seed);
    b5 = 8'(i * 7 + seed);
    return {b0, b1, b2, b3, b4, b5};
  endfunction

  // R3: offsets 0,1,4,5,8,9 carry address bytes 0..5; other offsets get filler
  function automatic logic [7:0] buf_byte(int seed, int i, int off, bit grp);
    logic [47:0] a;
    a = mk_addr(seed, i, grp);
    case (off)
      0: return a[47:40];
      1: return a[39:32];
      4: return a[31:24];
      5: return a[23:16];
      8: return a[15:8];
      9: return a[7:0];
      default: return 8'hA5 ^ 8'(off * 17 + i);
    endcase
  endfunction

  function automatic bit exp_accept(logic [47:0] a, bit prom);
    bit r;
    r = prom || a[40];
    for (int k = 0; k < exp_cnt; k++) if (exp_tab[k] == a) r = 1;
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_load(int seed, logic [15:0] gmask);
    exp_cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (!gmask[i]) begin
        exp_tab[exp_cnt] = mk_addr(seed, i, 1'b0);
        exp_cnt++;
      end
    end
  endtask

  task automatic load(int seed, logic [15:0] gmask);
    @(negedge clk) load_start = 1'b1;
    @(negedge clk) load_start = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R5 count cleared", entry_count, 0);
    for (int i = 0; i < N; i++) begin
      for (int off = 0; off < EB; off++) begin
        load_valid = 1'b1;
        load_byte  = buf_byte(seed, i, off, gmask[i]);
        @(negedge clk);
      end
    end
    load_valid = 1'b0;
    model_load(seed, gmask);
    check("R2 busy low after 192 bytes", busy, 0);
    check("R4 entry count", entry_count, exp_cnt);
  endtask

  task automatic ask(string req, logic [47:0] a, bit prom);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = a; promisc_en = prom;
    @(negedge clk);
    chk_valid = 1'b0; promisc_en = 1'b0;
    check({req, " valid"}, acc_valid, 1);
    check({req, " flag"}, acc_flag, exp_accept(a, prom));
  endtask

  task automatic sweep(int seed, logic [15:0] gmask);
    load(seed, gmask);
    for (int i = 0; i < N; i++) begin
      ask("R8 R3 own unicast", mk_addr(seed, i, 1'b0), 1'b0);
      ask("R8 near miss", mk_addr(seed, i, 1'b0) ^ 48'h1, 1'b0);
      ask("R7 group", mk_addr(seed, i, 1'b1), 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_start = 1'b0; load_valid = 1'b0; load_byte = '0;
    promisc_en = 1'b0; chk_valid = 1'b0; chk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 acc_valid", acc_valid, 0);
    check("R1 count", entry_count, 0);
    ask("R9 empty table unicast", mk_addr(1, 0, 1'b0), 1'b0);

    // sweeps; the second load reuses seed 1 with all groups: stale storage must not match (R5)
    sweep(1, 16'h0000);
    sweep(1, 16'hFFFF);
    sweep(2, 16'hAAAA);
    sweep(3, 16'h8001);
    sweep(4, 16'h7FFE);

    // R6 promiscuous
    ask("R6 promisc unknown unicast", 48'h0A1122334455, 1'b1);
    ask("R6 no promisc unknown unicast", 48'h0A1122334455, 1'b0);
    check("R6 reject without promisc", acc_flag, 0);

    // R11 stray bytes while idle
    for (int k = 0; k < 24; k++) begin
      load_valid = 1'b1; load_byte = 8'(8'h02 + k);
      @(negedge clk);
    end
    load_valid = 1'b0;
    check("R11 count unchanged", entry_count, exp_cnt);
    check("R11 busy stays low", busy, 0);
    ask("R11 stray address rejected", 48'h020304050607, 1'b0);
    ask("R11 old entry still kept", mk_addr(4, 0, 1'b0), 1'b0);

    // R12 restart mid-load, then full load of a new seed
    @(negedge clk) load_start = 1'b1;
    @(negedge clk) load_start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      load_valid = 1'b1; load_byte = buf_byte(9, k / EB, k % EB, 1'b0);
      @(negedge clk);
    end
    load_valid = 1'b0;
    load(10, 16'h00F0);
    check("R12 count after restart", entry_count, 12);
    ask("R12 partial load gone", mk_addr(9, 0, 1'b0), 1'b0);
    ask("R12 new entry present", mk_addr(10, 15, 1'b0), 1'b0);

    // R10 request held during a load, answered against the new table
    @(negedge clk) load_start = 1'b1;
    @(negedge clk) load_start = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int off = 0; off < EB; off++) begin
        load_valid = 1'b1;
        load_byte  = buf_byte(11, i, off, 1'b0);
        if (i == 3 && off == 0) begin
          chk_valid = 1'b1; chk_addr = mk_addr(11, 15, 1'b0);
        end
        if (i == 3 && off == 2) check("R10 no result while busy", acc_valid, 0);
        @(negedge clk);
        chk_valid = 1'b0;
      end
    end
    load_valid = 1'b0;
    model_load(11, 16'h0000);
    check("R10 busy fell", busy, 0);
    check("R10 not yet answered", acc_valid, 0);
    @(negedge clk);
    check("R10 held result valid", acc_valid, 1);
    check("R10 held result uses new table", acc_flag, 1);
    @(negedge clk);
    check("R10 single result", acc_valid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule